// File: doc/BRIEF.md
# Command Issue Stall and Interrupt Controller

This block sits between a command fetch stage and the command execution stage. In every cycle it decides whether the command that fetch presents may issue, must wait, must be held back, or must be thrown away as a no-op. It keeps a small set of sticky status flags: force-break, stop, interrupt-stall, two error indications and an interrupt flag. It also keeps a hidden loop-prevention flag, so that a command carrying an interrupt request raises that interrupt only once.

The flags that stop issue are force-break, stop and interrupt-stall. The error indications never stop issue by themselves. An error event stalls the stream only by also setting interrupt-stall, and its mask bit can prevent this. Software clears flags through a one-cycle clear vector. The processing state output reports idle, wait or stall. A one-cycle interrupt pulse goes out each time the interrupt flag becomes set.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: An active-low asynchronous reset clears all six status flags, the loop-prevention flag and `irq_o`. Right after reset, a plain command issues at once.
- R2: While `st_fbrk`, `st_stop` or `st_istall` is set, `issue` and `drop` stay low and `pstate` reads stall (2'b10), whatever the command inputs are.
- R3: `st_err0` and `st_err1` are indications only. With either set and no blocking flag set, a plain command issues.
- R4: A command with `cmd_irq` set that arrives while the loop flag is clear sets `st_int` and sets the loop flag. If it is not a mark command it does not issue in that cycle. When the same command is presented again it does not raise the interrupt again and goes on to the normal issue decision. The loop flag clears when a command issues or is dropped.
- R5: Raising an interrupt also sets `st_istall`, unless `mask_mii` is set.
- R6: A mark command (`cmd_is_mark`) with `cmd_irq` set issues in the same cycle in which it raises the interrupt.
- R7: An illegal command (`cmd_illegal`) sets `st_err1` and `st_istall` and does not issue when `mask_me1` is clear. With `mask_me1` set it pulses `drop` for one cycle and changes no flag.
- R8: An operand error event (`opnd_err`) sets `st_err0` and `st_istall` when `mask_me0` is clear. It has no effect when `mask_me0` is set.
- R9: Clear vector `clr_stat` bit map: bit0 clears `st_istall`, bit1 `st_err0`, bit2 `st_err1`, bit3 `st_int`, bit4 both `st_fbrk` and `st_stop`. A set event in the same cycle wins over the clear. Issue resumes in the cycle after the clearing edge.
- R10: `irq_o` is high for exactly one cycle, the cycle in which `st_int` first reads 1 after having been 0.
- R11: Decision order for an unblocked valid command: interrupt raise first, then the illegal check, then dependency wait. With `dep_busy` set, `issue` stays low and `pstate` reads wait (2'b01). Otherwise `pstate` reads idle (2'b00).
- R12: `brk_req` sets `st_fbrk` and `stop_req` sets `st_stop`. Both stay set until cleared through bit 4 of `clr_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A fetched command is presented |
| cmd_irq | input | 1 | Interrupt bit of the presented command |
| cmd_is_mark | input | 1 | Presented command is the mark command |
| cmd_illegal | input | 1 | Presented command is illegal |
| dep_busy | input | 1 | Resource the command depends on is busy |
| brk_req | input | 1 | Force-break request |
| stop_req | input | 1 | Stop request |
| opnd_err | input | 1 | Operand error event from the operand path |
| clr_stat | input | 5 | One-cycle flag clear vector |
| mask_mii | input | 1 | Mask interrupt-caused stall |
| mask_me0 | input | 1 | Mask operand error |
| mask_me1 | input | 1 | Mask illegal-command error |
| issue | output | 1 | Presented command issues this cycle |
| drop | output | 1 | Presented command is consumed as a no-op |
| pstate | output | 2 | 00 idle, 01 wait, 10 stall |
| st_fbrk | output | 1 | Force-break flag |
| st_stop | output | 1 | Stop flag |
| st_istall | output | 1 | Interrupt-stall flag |
| st_err0 | output | 1 | Operand error indication |
| st_err1 | output | 1 | Illegal-command indication |
| st_int | output | 1 | Interrupt flag |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume that the fetch stage keeps a held command stable and presents it again until it issues or is dropped. They also assume that the mark and illegal qualifiers are never both set. The stimulus table respects both rules. Each held interrupt command is re-presented with identical bits in the following rows, and no row marks a command as both mark and illegal. Inputs change only at the falling clock edge, so each combinational decision is settled before the edge that registers its flags.

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_irq,
  input  logic       cmd_is_mark,
  input  logic       cmd_illegal,
  input  logic       dep_busy,
  input  logic       brk_req,
  input  logic       stop_req,
  input  logic       opnd_err,
  input  logic [4:0] clr_stat,
  input  logic       mask_mii,
  input  logic       mask_me0,
  input  logic       mask_me1,
  output logic       issue,
  output logic       drop,
  output logic [1:0] pstate,
  output logic       st_fbrk,
  output logic       st_stop,
  output logic       st_istall,
  output logic       st_err0,
  output logic       st_err1,
  output logic       st_int,
  output logic       irq_o
);
  localparam logic [1:0] PS_IDLE  = 2'b00;
  localparam logic [1:0] PS_WAIT  = 2'b01;
  localparam logic [1:0] PS_STALL = 2'b10;

  logic loop_q;
  logic blocked, attempt, raise, ill_err, er0_hit;

  assign blocked = st_fbrk | st_stop | st_istall;
  assign attempt = cmd_valid & ~blocked;
  assign raise   = attempt & cmd_irq & ~loop_q;
  assign ill_err = attempt & ~raise & cmd_illegal & ~mask_me1;
  assign drop    = attempt & ~raise & cmd_illegal & mask_me1;
  assign issue   = attempt & ~cmd_illegal & ~dep_busy & (~raise | cmd_is_mark);
  assign er0_hit = opnd_err & ~mask_me0;

  always_comb begin
    if (blocked)                                       pstate = PS_STALL;
    else if (attempt & ~raise & ~cmd_illegal & dep_busy) pstate = PS_WAIT;
    else                                               pstate = PS_IDLE;
  end

  logic int_n;
  assign int_n = raise | (st_int & ~clr_stat[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_fbrk   <= 1'b0;
      st_stop   <= 1'b0;
      st_istall <= 1'b0;
      st_err0   <= 1'b0;
      st_err1   <= 1'b0;
      st_int    <= 1'b0;
      irq_o     <= 1'b0;
      loop_q    <= 1'b0;
    end else begin
      st_fbrk   <= brk_req | (st_fbrk & ~clr_stat[4]);
      st_stop   <= stop_req | (st_stop & ~clr_stat[4]);
      st_istall <= (raise & ~mask_mii) | ill_err | er0_hit | (st_istall & ~clr_stat[0]);
      st_err0   <= er0_hit | (st_err0 & ~clr_stat[1]);
      st_err1   <= ill_err | (st_err1 & ~clr_stat[2]);
      st_int    <= int_n;
      irq_o     <= int_n & ~st_int;
      loop_q    <= (issue | drop) ? 1'b0 : (raise | loop_q);
    end
  end
endmodule

module cmd_issue_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_illegal,
  input logic       cmd_is_mark,
  input logic       mask_me1,
  input logic       issue,
  input logic       drop,
  input logic [1:0] pstate,
  input logic       st_fbrk,
  input logic       st_stop,
  input logic       st_istall,
  input logic       st_err1,
  input logic       st_int,
  input logic       irq_o
);
  // R2
  no_issue_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fbrk || st_stop || st_istall) |-> (!issue && !drop && pstate == 2'b10));
  // R7
  drop_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (mask_me1 && cmd_illegal && !issue));
  // R7
  err1_brings_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err1) |-> st_istall);
  // R10
  irq_on_int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_int && !$past(st_int)));
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R4
  held_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_int) && !$past(cmd_is_mark)) |-> !$past(issue));
endmodule

bind cmd_issue_ctrl cmd_issue_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_illegal(cmd_illegal), .cmd_is_mark(cmd_is_mark),
  .mask_me1(mask_me1), .issue(issue), .drop(drop), .pstate(pstate),
  .st_fbrk(st_fbrk), .st_stop(st_stop), .st_istall(st_istall),
  .st_err1(st_err1), .st_int(st_int), .irq_o(irq_o)
);

// File: tb/cmd_issue_ctrl_bench.sv
module cmd_issue_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid, cmd_irq, cmd_is_mark, cmd_illegal, dep_busy;
  logic brk_req, stop_req, opnd_err, mask_mii, mask_me0, mask_me1;
  logic [4:0] clr_stat;
  logic issue, drop, st_fbrk, st_stop, st_istall, st_err0, st_err1, st_int, irq_o;
  logic [1:0] pstate;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_issue_ctrl u_cmd_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_irq(cmd_irq),
    .cmd_is_mark(cmd_is_mark), .cmd_illegal(cmd_illegal), .dep_busy(dep_busy),
    .brk_req(brk_req), .stop_req(stop_req), .opnd_err(opnd_err), .clr_stat(clr_stat),
    .mask_mii(mask_mii), .mask_me0(mask_me0), .mask_me1(mask_me1),
    .issue(issue), .drop(drop), .pstate(pstate), .st_fbrk(st_fbrk), .st_stop(st_stop),
    .st_istall(st_istall), .st_err0(st_err0), .st_err1(st_err1), .st_int(st_int),
    .irq_o(irq_o)
  );

  // inputs: valid irq mark ill busy brk stop oerr | clr[4:0] | mii me0 me1
  // expect: issue drop pstate[1:0] | fbrk stop istall err0 err1 int | irq
  localparam logic [26:0] VEC [0:NV-1] = '{
    {16'b1000_0000_00000_000, 11'b1000_000000_0}, // R1 plain issue
    {16'b1000_1000_00000_000, 11'b0001_000000_0}, // R11 wait
    {16'b1100_0000_00000_000, 11'b0000_001001_1}, // R4 raise, held
    {16'b1100_0000_00000_000, 11'b0010_001001_0}, // R5 stalled
    {16'b1100_0000_00001_000, 11'b0010_000001_0}, // R9 clear istall
    {16'b1100_0000_00000_000, 11'b1000_000001_0}, // R4 no re-raise
    {16'b0000_0000_01000_000, 11'b0000_000000_0}, // R9 clear int
    {16'b1100_0000_00000_100, 11'b0000_000001_1}, // R5 masked stall
    {16'b1100_0000_00000_100, 11'b1000_000001_0}, // R4 then issues
    {16'b0000_0000_01000_000, 11'b0000_000000_0}, // R9
    {16'b1110_0000_00000_000, 11'b1000_001001_1}, // R6 mark issues
    {16'b0000_0000_01001_000, 11'b0010_000000_0}, // R9
    {16'b1001_0000_00000_000, 11'b0000_001010_0}, // R7 illegal
    {16'b0000_0000_00000_000, 11'b0010_001010_0}, // R2
    {16'b0000_0000_00001_000, 11'b0010_000010_0}, // R9
    {16'b1000_0000_00000_000, 11'b1000_000010_0}, // R3 err1 no stall
    {16'b0000_0000_00100_000, 11'b0000_000000_0}, // R9
    {16'b1001_0000_00000_001, 11'b0100_000000_0}, // R7 dropped
    {16'b0000_0001_00000_000, 11'b0000_001100_0}, // R8
    {16'b0000_0000_00011_000, 11'b0010_000000_0}, // R9
    {16'b0000_0001_00000_010, 11'b0000_000000_0}, // R8 masked
    {16'b0000_0100_00000_000, 11'b0000_100000_0}, // R12 break
    {16'b1000_0000_00000_000, 11'b0010_100000_0}, // R2
    {16'b0000_0010_00000_000, 11'b0010_110000_0}, // R12 stop
    {16'b0000_0000_10000_000, 11'b0010_000000_0}, // R12 resume
    {16'b1000_0000_00000_000, 11'b1000_000000_0}, // R9 resumes
    {16'b0000_0001_00010_000, 11'b0000_001100_0}, // R9 set wins
    {16'b0000_0000_00011_000, 11'b0010_000000_0}, // R9
    {16'b1101_0000_00000_100, 11'b0000_000001_1}, // R11 raise first
    {16'b1101_0000_00000_100, 11'b0000_001011_0}  // R11 then illegal
  };
  localparam int VTAG [0:NV-1] = '{1,11,4,5,9,4,9,5,4,9,6,9,7,2,9,3,9,7,8,9,8,12,2,12,12,9,9,9,11,11};

  task automatic apply(input logic [15:0] v);
    {cmd_valid, cmd_irq, cmd_is_mark, cmd_illegal, dep_busy, brk_req, stop_req, opnd_err,
     clr_stat, mask_mii, mask_me0, mask_me1} = v;
  endtask

  task automatic chk(input int tag, input string what, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    apply(16'b0);
    #(CLK_PERIOD*2);
    // R1 reset state
    chk(1, "reset flags", {4'b0, st_fbrk, st_stop, st_istall, st_err0, st_err1, st_int, irq_o}, 11'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][26:11]);
      #1;
      chk(VTAG[i], $sformatf("row %0d decision", i), {7'b0, issue, drop, pstate},
          {7'b0, VEC[i][10:7]});
      @(posedge clk); #1;
      chk(VTAG[i], $sformatf("row %0d flags", i),
          {4'b0, st_fbrk, st_stop, st_istall, st_err0, st_err1, st_int, irq_o},
          {4'b0, VEC[i][6:0]});
    end
    // R1 asynchronous reset from a busy flag state
    @(negedge clk); apply(16'b0000_0110_00000_000);
    @(negedge clk); apply(16'b0); rst_n = 1'b0; #1;
    chk(1, "async reset flags", {4'b0, st_fbrk, st_stop, st_istall, st_err0, st_err1, st_int, irq_o}, 11'b0);
    @(negedge clk); rst_n = 1'b1;
    apply(16'b1000_0000_00000_000); #1;
    chk(1, "issue after reset", {7'b0, issue, drop, pstate}, {7'b0, 4'b1000});
    @(negedge clk); apply(16'b0);
    #(CLK_PERIOD);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule